// File: doc/BRIEF.md
# Parallel Camera Timing Pattern Generator

This block is a synthesizable stand-in for a parallel-bus image sensor. It runs on the pixel clock and drives three things: a frame sync, an active-high line-valid strobe and a byte-wide data bus. A receiver or capture path can be driven and checked with it, and no real sensor is needed. The nominal pixel clock is 24 MHz. At the default settings a frame carries 720 lines of 1080 two-byte pixels, so each line is 2160 bytes.

A frame is built from a sequence of phases. First comes a short low period. Then the sync goes high for a fixed pulse width and falls. A settle gap follows, and then the lines. Each line is a burst with line-valid high, followed by horizontal blanking with line-valid low. After the blanking of the last line there is an optional idle gap, and then the next frame starts. The data bus carries a counting pattern, so a checker can predict every byte from its position in the frame. Two single-cycle marker outputs flag the start of each frame and the start of each line, so that a bench model can align to the stream.

Top module: `dvp_pattern_gen`

## Requirements
- R1: While rst_n is low, vsync_o, href_o, data_o, frame_start_o and line_start_o are all zero. After release the sequence restarts from the low phase that comes before the sync pulse.
- R2: Count rising edges from reset release, or from the start of a frame. vsync_o goes high after edge PRE_CLKS, stays high for VS_CLKS cycles and then returns low. vsync_o is never high at the same time as href_o.
- R3: After vsync_o falls, href_o stays low for SETTLE_CLKS cycles before the first line begins.
- R4: Each frame contains exactly LINES lines. In each line href_o is high for exactly BYTES_PER_LINE consecutive cycles.
- R5: After every line, including the last one, href_o is low for exactly HBLANK_CLKS cycles.
- R6: After the blanking of the last line, vsync_o and href_o both stay low for IFG_CLKS idle cycles (zero is allowed). Then the next frame begins with its pre-sync low phase, so the frame period is PRE_CLKS+VS_CLKS+SETTLE_CLKS+LINES*(BYTES_PER_LINE+HBLANK_CLKS)+IFG_CLKS cycles.
- R7: On the k-th href_o-high cycle of a frame, counting from k=0, data_o equals k modulo 2^DATA_W. The count carries on across lines, so data_o rises by one on each consecutive href_o-high cycle and wraps from 255 to 0 when DATA_W is 8.
- R8: While href_o is low between lines, data_o holds the last byte sent. data_o is zero during the idle gap, the pre-sync phase, the sync pulse and the settle gap.
- R9: frame_start_o is high for exactly one cycle per frame, in the first cycle that vsync_o is high. line_start_o is high for exactly one cycle per line, in the first cycle that href_o is high.
- R10: All outputs come from registers clocked on the rising edge of pclk, so they are steady when sampled away from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsync_o | output | 1 | Frame sync pulse, active high |
| href_o | output | 1 | Line-valid strobe, high while data_o carries a byte |
| data_o | output | DATA_W | Pattern byte |
| frame_start_o | output | 1 | One-cycle marker on the first sync-high cycle |
| line_start_o | output | 1 | One-cycle marker on the first byte of each line |

## Verification
A wrong phase or a wrong counter value inside the sequencer shows up at the ports within one cycle. It appears as a sync edge, a line edge or a marker pulse that comes one or more cycles early or late, and the bench compares every output on every cycle against a position-in-frame model, so such a shift is caught in the cycle it happens. A wrong byte counter shows as a data_o mismatch on the next line-valid cycle. A byte counter that fails to clear only shows when the next frame's first byte is not zero, so the bench runs more than one frame and includes a reset applied in the middle of a line.

// File: rtl/dvp_gen_pkg.sv
package dvp_gen_pkg;
   typedef enum logic [2:0] {
      PH_PRE    = 3'd0,
      PH_VS     = 3'd1,
      PH_SETTLE = 3'd2,
      PH_ACTIVE = 3'd3,
      PH_HBLANK = 3'd4,
      PH_IFG    = 3'd5
   } phase_e;
endpackage

// File: rtl/dvp_gen_timing.sv
module dvp_gen_timing
   import dvp_gen_pkg::*;
#(
   parameter int LINES          = 720,
   parameter int BYTES_PER_LINE = 2160,
   parameter int PRE_CLKS       = 10,
   parameter int VS_CLKS        = 10,
   parameter int SETTLE_CLKS    = 100,
   parameter int HBLANK_CLKS    = 100,
   parameter int IFG_CLKS       = 16,
   parameter int CNT_W          = 12,
   parameter int LINE_W         = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   output phase_e           phase_d,
   output logic [CNT_W-1:0] cnt_d
);
   localparam logic [CNT_W-1:0]  PRE_LAST  = CNT_W'(PRE_CLKS - 1);
   localparam logic [CNT_W-1:0]  VS_LAST   = CNT_W'(VS_CLKS - 1);
   localparam logic [CNT_W-1:0]  SET_LAST  = CNT_W'(SETTLE_CLKS - 1);
   localparam logic [CNT_W-1:0]  ACT_LAST  = CNT_W'(BYTES_PER_LINE - 1);
   localparam logic [CNT_W-1:0]  HBL_LAST  = CNT_W'(HBLANK_CLKS - 1);
   localparam logic [CNT_W-1:0]  IFG_LAST  = CNT_W'((IFG_CLKS > 0) ? IFG_CLKS - 1 : 0);
   localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

   phase_e              phase_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [LINE_W-1:0]   line_q;
   logic [LINE_W-1:0]   line_d;
   phase_e              after_frame;

   // the phase entered after the last blanking depends on the idle gap
   generate
      if (IFG_CLKS > 0) begin : g_with_gap
         assign after_frame = PH_IFG;
      end else begin : g_no_gap
         assign after_frame = PH_PRE;
      end
   endgenerate

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q + CNT_W'(1);
      line_d  = line_q;
      unique case (phase_q)
         PH_PRE: begin
            if (cnt_q == PRE_LAST) begin
               phase_d = PH_VS;
               cnt_d   = '0;
            end
         end
         PH_VS: begin
            if (cnt_q == VS_LAST) begin
               phase_d = PH_SETTLE;
               cnt_d   = '0;
            end
         end
         PH_SETTLE: begin
            if (cnt_q == SET_LAST) begin
               phase_d = PH_ACTIVE;
               cnt_d   = '0;
               line_d  = '0;
            end
         end
         PH_ACTIVE: begin
            if (cnt_q == ACT_LAST) begin
               phase_d = PH_HBLANK;
               cnt_d   = '0;
            end
         end
         PH_HBLANK: begin
            if (cnt_q == HBL_LAST) begin
               cnt_d = '0;
               if (line_q == LINE_LAST) begin
                  phase_d = after_frame;
                  line_d  = '0;
               end else begin
                  phase_d = PH_ACTIVE;
                  line_d  = line_q + LINE_W'(1);
               end
            end
         end
         PH_IFG: begin
            if (cnt_q == IFG_LAST) begin
               phase_d = PH_PRE;
               cnt_d   = '0;
            end
         end
         default: begin
            phase_d = PH_PRE;
            cnt_d   = '0;
            line_d  = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_PRE;
         cnt_q   <= '0;
         line_q  <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         line_q  <= line_d;
      end
   end
endmodule

// File: rtl/dvp_gen_bytes.sv
module dvp_gen_bytes #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              next_active,
   input  logic              next_body,
   output logic [DATA_W-1:0] data_q
);
   logic [DATA_W-1:0] byte_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_cnt_q <= '0;
         data_q     <= '0;
      end else if (next_active) begin
         data_q     <= byte_cnt_q;
         byte_cnt_q <= byte_cnt_q + DATA_W'(1);
      end else if (!next_body) begin
         data_q     <= '0;
         byte_cnt_q <= '0;
      end
   end
endmodule

// File: rtl/dvp_gen_strobes.sv
module dvp_gen_strobes
   import dvp_gen_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  phase_e           phase_d,
   input  logic [CNT_W-1:0] cnt_d,
   output logic             vsync_q,
   output logic             href_q,
   output logic             fstart_q,
   output logic             lstart_q
);
   logic first_d;
   assign first_d = (cnt_d == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vsync_q  <= 1'b0;
         href_q   <= 1'b0;
         fstart_q <= 1'b0;
         lstart_q <= 1'b0;
      end else begin
         vsync_q  <= (phase_d == PH_VS);
         href_q   <= (phase_d == PH_ACTIVE);
         fstart_q <= (phase_d == PH_VS) && first_d;
         lstart_q <= (phase_d == PH_ACTIVE) && first_d;
      end
   end
endmodule

// File: rtl/dvp_pattern_gen.sv
module dvp_pattern_gen
   import dvp_gen_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int LINES          = 720,
   parameter int BYTES_PER_LINE = 2160,
   parameter int PRE_CLKS       = 10,
   parameter int VS_CLKS        = 10,
   parameter int SETTLE_CLKS    = 100,
   parameter int HBLANK_CLKS    = 100,
   parameter int IFG_CLKS       = 16
) (
   input  logic              pclk,
   input  logic              rst_n,
   output logic              vsync_o,
   output logic              href_o,
   output logic [DATA_W-1:0] data_o,
   output logic              frame_start_o,
   output logic              line_start_o
);
   localparam int MAX_A  = (PRE_CLKS > VS_CLKS) ? PRE_CLKS : VS_CLKS;
   localparam int MAX_B  = (SETTLE_CLKS > HBLANK_CLKS) ? SETTLE_CLKS : HBLANK_CLKS;
   localparam int MAX_C  = (BYTES_PER_LINE > IFG_CLKS) ? BYTES_PER_LINE : IFG_CLKS;
   localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAXLEN = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
   localparam int CNT_W  = $clog2(MAXLEN + 1);
   localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;

   // parameter legality, checked at elaboration
   if (DATA_W < 1)         begin : g_bad_dw  $error("DATA_W must be at least 1"); end
   if (LINES < 1)          begin : g_bad_ln  $error("LINES must be at least 1"); end
   if (BYTES_PER_LINE < 1) begin : g_bad_bpl $error("BYTES_PER_LINE must be at least 1"); end
   if (PRE_CLKS < 1)       begin : g_bad_pre $error("PRE_CLKS must be at least 1"); end
   if (VS_CLKS < 1)        begin : g_bad_vs  $error("VS_CLKS must be at least 1"); end
   if (SETTLE_CLKS < 1)    begin : g_bad_set $error("SETTLE_CLKS must be at least 1"); end
   if (HBLANK_CLKS < 1)    begin : g_bad_hbl $error("HBLANK_CLKS must be at least 1"); end
   if (IFG_CLKS < 0)       begin : g_bad_ifg $error("IFG_CLKS must not be negative"); end

   phase_e           phase_d;
   logic [CNT_W-1:0] cnt_d;
   logic             next_active;
   logic             next_body;

   assign next_active = (phase_d == PH_ACTIVE);
   assign next_body   = (phase_d == PH_ACTIVE) || (phase_d == PH_HBLANK);

   dvp_gen_timing #(
      .LINES          (LINES),
      .BYTES_PER_LINE (BYTES_PER_LINE),
      .PRE_CLKS       (PRE_CLKS),
      .VS_CLKS        (VS_CLKS),
      .SETTLE_CLKS    (SETTLE_CLKS),
      .HBLANK_CLKS    (HBLANK_CLKS),
      .IFG_CLKS       (IFG_CLKS),
      .CNT_W          (CNT_W),
      .LINE_W         (LINE_W)
   ) timing_i (
      .clk     (pclk),
      .rst_n   (rst_n),
      .phase_d (phase_d),
      .cnt_d   (cnt_d)
   );

   dvp_gen_bytes #(
      .DATA_W (DATA_W)
   ) bytes_i (
      .clk         (pclk),
      .rst_n       (rst_n),
      .next_active (next_active),
      .next_body   (next_body),
      .data_q      (data_o)
   );

   dvp_gen_strobes #(
      .CNT_W (CNT_W)
   ) strobes_i (
      .clk      (pclk),
      .rst_n    (rst_n),
      .phase_d  (phase_d),
      .cnt_d    (cnt_d),
      .vsync_q  (vsync_o),
      .href_q   (href_o),
      .fstart_q (frame_start_o),
      .lstart_q (line_start_o)
   );
endmodule

// File: rtl/dvp_pattern_gen_chk.sv
module dvp_pattern_gen_chk #(
   parameter int DATA_W         = 8,
   parameter int BYTES_PER_LINE = 2160,
   parameter int VS_CLKS        = 10
) (
   input logic              pclk,
   input logic              rst_n,
   input logic              vsync_o,
   input logic              href_o,
   input logic [DATA_W-1:0] data_o,
   input logic              frame_start_o,
   input logic              line_start_o
);
   int unsigned href_run_q;
   int unsigned vs_run_q;

   always_ff @(posedge pclk or negedge rst_n) begin
      if (!rst_n) begin
         href_run_q <= 0;
         vs_run_q   <= 0;
      end else begin
         href_run_q <= href_o  ? href_run_q + 1 : 0;
         vs_run_q   <= vsync_o ? vs_run_q + 1 : 0;
      end
   end

   // R1
   always @(posedge pclk) begin
      if (!rst_n) begin
         rst_quiet_chk: assert (!vsync_o && !href_o && data_o == '0 && !frame_start_o && !line_start_o)
            else $error("outputs not zero in reset");
      end
   end

   // R2
   sync_width_chk: assert property (@(posedge pclk) disable iff (!rst_n)
      $fell(vsync_o) |-> vs_run_q == VS_CLKS);

   // R2
   sync_line_excl_chk: assert property (@(posedge pclk) disable iff (!rst_n)
      !(vsync_o && href_o));

   // R4
   line_width_chk: assert property (@(posedge pclk) disable iff (!rst_n)
      $fell(href_o) |-> href_run_q == BYTES_PER_LINE);

   // R7
   data_step_chk: assert property (@(posedge pclk) disable iff (!rst_n)
      href_o && $past(href_o) |-> data_o == DATA_W'($past(data_o) + 1'b1));

   // R8
   data_hold_chk: assert property (@(posedge pclk) disable iff (!rst_n)
      $fell(href_o) |-> $stable(data_o));

   // R9
   frame_mark_chk: assert property (@(posedge pclk) disable iff (!rst_n)
      frame_start_o == $rose(vsync_o));

   // R9
   line_mark_chk: assert property (@(posedge pclk) disable iff (!rst_n)
      line_start_o == $rose(href_o));
endmodule

bind dvp_pattern_gen dvp_pattern_gen_chk #(
   .DATA_W         (DATA_W),
   .BYTES_PER_LINE (BYTES_PER_LINE),
   .VS_CLKS        (VS_CLKS)
) chk_i (
   .pclk          (pclk),
   .rst_n         (rst_n),
   .vsync_o       (vsync_o),
   .href_o        (href_o),
   .data_o        (data_o),
   .frame_start_o (frame_start_o),
   .line_start_o  (line_start_o)
);

// File: tb/dvp_pattern_gen_tb_top.sv
module dvp_pattern_gen_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam int  DW   = 8;
   localparam int  LN   = 3;
   localparam int  BPL  = 100;
   localparam int  PRE  = 4;
   localparam int  VSW  = 3;
   localparam int  SET  = 6;
   localparam int  HBL  = 5;
   localparam int  IFG  = 7;
   localparam int  LLEN = BPL + HBL;
   localparam int  BASE = PRE + VSW + SET;
   localparam int  FLEN = BASE + LN * LLEN + IFG;

   logic          pclk = 1'b0;
   logic          rst_n = 1'b0;
   logic          vsync_o, href_o, frame_start_o, line_start_o;
   logic [DW-1:0] data_o;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD / 2) pclk = ~pclk;

   dvp_pattern_gen #(
      .DATA_W (DW), .LINES (LN), .BYTES_PER_LINE (BPL), .PRE_CLKS (PRE),
      .VS_CLKS (VSW), .SETTLE_CLKS (SET), .HBLANK_CLKS (HBL), .IFG_CLKS (IFG)
   ) dut_i (
      .pclk (pclk), .rst_n (rst_n), .vsync_o (vsync_o), .href_o (href_o),
      .data_o (data_o), .frame_start_o (frame_start_o), .line_start_o (line_start_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // expected outputs after t rising edges since reset release
   task automatic model(input int t, output int vs, output int hr, output int d,
                        output int fs, output int ls);
      int pos;
      pos = t % FLEN;
      vs = 0; hr = 0; d = 0; fs = 0; ls = 0;
      if (pos >= PRE && pos < PRE + VSW) begin
         vs = 1;
         fs = (pos == PRE) ? 1 : 0;
      end else if (pos >= BASE && pos < BASE + LN * LLEN) begin
         int l, c;
         l = (pos - BASE) / LLEN;
         c = (pos - BASE) % LLEN;
         if (c < BPL) begin
            hr = 1;
            d  = (l * BPL + c) % 256;
            ls = (c == 0) ? 1 : 0;
         end else begin
            d = (l * BPL + BPL - 1) % 256;
         end
      end
   endtask

   // compares every output on ncyc consecutive cycles, starting at edge count t0
   task automatic run_and_compare(input int t0, input int ncyc,
                                  output int frames, output int lines);
      int vs, hr, d, fs, ls;
      frames = 0;
      lines  = 0;
      for (int t = t0; t < t0 + ncyc; t++) begin
         model(t, vs, hr, d, fs, ls);
         check("R2 vsync", int'(vsync_o), vs);
         check("R4/R5 href", int'(href_o), hr);
         check("R7/R8 data", int'(data_o), d);
         check("R9 frame_start", int'(frame_start_o), fs);
         check("R9 line_start", int'(line_start_o), ls);
         frames += int'(frame_start_o);
         lines  += int'(line_start_o);
         @(negedge pclk);
      end
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      repeat (3) @(negedge pclk);
      // R1 outputs held at zero in reset
      check("R1 vsync", int'(vsync_o), 0);
      check("R1 href", int'(href_o), 0);
      check("R1 data", int'(data_o), 0);
      check("R1 markers", int'(frame_start_o) + int'(line_start_o), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_two_frames();
      int frames, lines;
      // R3 R6 full timeline over two frames and the start of a third
      run_and_compare(0, 2 * FLEN + BASE + 2, frames, lines);
      check("R9 frame pulses", frames, 3);
      // R4 lines per frame
      check("R4 line pulses", lines, 2 * LN + 1);
   endtask

   task automatic t_midline_reset();
      int frames, lines;
      rst_n = 1'b0;
      @(negedge pclk);
      // R1 asynchronous clear in the middle of a line
      check("R1 vsync", int'(vsync_o), 0);
      check("R1 href", int'(href_o), 0);
      check("R1 data", int'(data_o), 0);
      @(negedge pclk);
      rst_n = 1'b1;
      // R1 restart from the pre-sync phase; R7 first byte zero again
      run_and_compare(0, FLEN + PRE + 1, frames, lines);
      check("R1 restart frames", frames, 2);
   endtask

   initial begin
      @(negedge pclk);
      t_reset_state();
      t_two_frames();
      // move into the second line of the next frame before resetting
      repeat (LLEN + 20) @(negedge pclk);
      check("R10 href mid-line", int'(href_o), 1);
      t_midline_reset();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule